// File: doc/BRIEF.md
# Five-Operand Modular Adder with Column Counters

This block adds five unsigned operands of a parameterised width and returns their sum wrapped to that width. It is fully combinational. Each bit position gathers the five operand bits of that position and counts the ones among them into a three-bit number. That count takes only the values zero to five.

The low, middle and high bits of all the column counts form three vectors. Their weights are one, two and four times the column weight. The middle vector is moved up one place and the high vector two places, and bits pushed past the top position are dropped. A single carry-save row turns these three aligned vectors into a partial-sum vector and a carry vector. The carry vector is moved up one place, also with the top bit dropped. A ripple propagate adder then adds the two vectors, and the carry out of the top position is discarded.

The block has no clock, no state and no control input. Its output follows its inputs, so it can sit inside any pipeline stage that needs a five-way sum, such as a small dot-product or a partial-product reducer.

Top module: `quint_sum`

## Requirements
- R1: For every bit position i, the column counter output is a three-bit number equal to the count of ones among op_a[i], op_b[i], op_c[i], op_d[i] and op_e[i], so it is never 6 or 7.
- R2: The three count vectors, weighted 1, 2 and 4 at each column and summed modulo 2^W, equal op_a+op_b+op_c+op_d+op_e modulo 2^W.
- R3: The carry-save row preserves the value: the partial-sum vector plus the carry vector moved up one place equals the sum of the three aligned count vectors, modulo 2^W.
- R4: total equals (op_a+op_b+op_c+op_d+op_e) mod 2^W for every input combination, checked exhaustively at W=3 and with random operands at W=16.
- R5: Carries beyond bit W-1 are discarded, so five all-ones operands give 2^W-5 and five operands of 2^(W-1) give 2^(W-1).
- R6: The output depends only on the present inputs: after any input change, total reflects the new operands with no clock edge involved.
- R7: Swapping operands between input ports does not change total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| op_c | input | W | Third operand |
| op_d | input | W | Fourth operand |
| op_e | input | W | Fifth operand |
| total | output | W | Sum of the five operands modulo 2^W |

## Verification
The internal checks assume that every operand bit is a known 0 or 1. An unknown bit would make the column counts and the value-preservation comparisons meaningless. The stimulus therefore drives every operand from defined integers at all times: zeros while the bench reset is held, an enumerated 15-bit index for the narrow instance, and fixed-seed $urandom values plus directed corner values for the wide one. Inputs change only on rising clock edges and are sampled on falling edges, so the combinational paths have settled before anything is compared.

// File: rtl/quint_sum_pkg.sv
package quint_sum_pkg;

    typedef logic [2:0] cnt3_t;

    // Ones count of a five-bit column, result 0..5.
    function automatic cnt3_t ones_of_five(input logic [4:0] bits_in);
        cnt3_t acc;
        acc = 3'd0;
        for (int k = 0; k < 5; k++) begin
            acc = acc + {2'b00, bits_in[k]};
        end
        return acc;
    endfunction

endpackage

// File: rtl/qs_counter5.sv
module qs_counter5
    import quint_sum_pkg::*;
(
    input  logic [4:0] col_bits,
    output cnt3_t      col_count
);
    always_comb begin
        col_count = ones_of_five(col_bits);
    end
endmodule

// File: rtl/qs_csa.sv
module qs_csa #(
    parameter int W = 16
) (
    input  logic [W-1:0] in_x,
    input  logic [W-1:0] in_y,
    input  logic [W-1:0] in_z,
    output logic [W-1:0] part_sum,
    output logic [W-1:0] part_cy
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            part_sum[i] = in_x[i] ^ in_y[i] ^ in_z[i];
            part_cy[i]  = (in_x[i] & in_y[i]) | (in_x[i] & in_z[i]) | (in_y[i] & in_z[i]);
        end
    end
endmodule

// File: rtl/qs_ripple.sv
module qs_ripple #(
    parameter int W = 16
) (
    input  logic [W-1:0] add_x,
    input  logic [W-1:0] add_y,
    output logic [W-1:0] add_s
);
    logic [W-1:0] chain;

    assign chain[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_fa
        assign add_s[i] = add_x[i] ^ add_y[i] ^ chain[i];
        if (i < W - 1) begin : g_carry
            assign chain[i+1] = (add_x[i] & add_y[i]) | (chain[i] & (add_x[i] ^ add_y[i]));
        end
    end
endmodule

// File: rtl/quint_sum.sv
module quint_sum
    import quint_sum_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [W-1:0] op_c,
    input  logic [W-1:0] op_d,
    input  logic [W-1:0] op_e,
    output logic [W-1:0] total
);
    // Count vectors: bit i of cnt_lo/mid/hi is bit 0/1/2 of column i's count.
    logic [W-1:0] cnt_lo;
    logic [W-1:0] cnt_mid;
    logic [W-1:0] cnt_hi;

    // Weight-aligned vectors fed to the carry-save row.
    logic [W-1:0] vec_one;
    logic [W-1:0] vec_two;
    logic [W-1:0] vec_four;

    logic [W-1:0] row_sum;
    logic [W-1:0] row_cy;
    logic [W-1:0] row_cy_up;

    for (genvar i = 0; i < W; i++) begin : g_col
        cnt3_t col_cnt;
        qs_counter5 u_cnt (
            .col_bits ({op_e[i], op_d[i], op_c[i], op_b[i], op_a[i]}),
            .col_count(col_cnt)
        );
        assign cnt_lo[i]  = col_cnt[0];
        assign cnt_mid[i] = col_cnt[1];
        assign cnt_hi[i]  = col_cnt[2];

        assign vec_one[i] = cnt_lo[i];
        if (i >= 1) begin : g_up1
            assign vec_two[i]   = cnt_mid[i-1];
            assign row_cy_up[i] = row_cy[i-1];
        end else begin : g_zero1
            assign vec_two[i]   = 1'b0;
            assign row_cy_up[i] = 1'b0;
        end
        if (i >= 2) begin : g_up2
            assign vec_four[i] = cnt_hi[i-2];
        end else begin : g_zero2
            assign vec_four[i] = 1'b0;
        end
    end

    qs_csa #(.W(W)) u_csa (
        .in_x    (vec_one),
        .in_y    (vec_two),
        .in_z    (vec_four),
        .part_sum(row_sum),
        .part_cy (row_cy)
    );

    qs_ripple #(.W(W)) u_cpa (
        .add_x(row_sum),
        .add_y(row_cy_up),
        .add_s(total)
    );
endmodule

// File: rtl/quint_sum_chk.sv
module quint_sum_chk #(
    parameter int W = 16
) (
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [W-1:0] op_c,
    input logic [W-1:0] op_d,
    input logic [W-1:0] op_e,
    input logic [W-1:0] cnt_lo,
    input logic [W-1:0] cnt_mid,
    input logic [W-1:0] cnt_hi,
    input logic [W-1:0] vec_one,
    input logic [W-1:0] vec_two,
    input logic [W-1:0] vec_four,
    input logic [W-1:0] row_sum,
    input logic [W-1:0] row_cy,
    input logic [W-1:0] total
);
    logic [W-1:0] ops_mod;
    logic [W-1:0] cnt_mod;
    logic [W-1:0] aligned_mod;
    logic [W-1:0] row_mod;

    always_comb begin
        ops_mod     = op_a + op_b + op_c + op_d + op_e;
        cnt_mod     = cnt_lo + (cnt_mid << 1) + (cnt_hi << 2);
        aligned_mod = vec_one + vec_two + vec_four;
        row_mod     = row_sum + (row_cy << 1);

        for (int i = 0; i < W; i++) begin
            // R1: column count matches ones in the column and stays below 6
            p_col_count_r1: assert ({cnt_hi[i], cnt_mid[i], cnt_lo[i]} ==
                3'($countones({op_a[i], op_b[i], op_c[i], op_d[i], op_e[i]})))
                else $error("column %0d count mismatch", i);
            p_col_range_r1: assert (!(cnt_hi[i] && cnt_mid[i]))
                else $error("column %0d count above five", i);
        end

        p_counter_sum_r2: assert (cnt_mod == ops_mod)
            else $error("count vectors lose value");
        p_csa_keep_r3: assert (row_mod == aligned_mod)
            else $error("carry-save row loses value");
        p_total_r4: assert (total == ops_mod)
            else $error("total wrong");
    end
endmodule

bind quint_sum quint_sum_chk #(.W(W)) u_chk (
    .op_a    (op_a),
    .op_b    (op_b),
    .op_c    (op_c),
    .op_d    (op_d),
    .op_e    (op_e),
    .cnt_lo  (cnt_lo),
    .cnt_mid (cnt_mid),
    .cnt_hi  (cnt_hi),
    .vec_one (vec_one),
    .vec_two (vec_two),
    .vec_four(vec_four),
    .row_sum (row_sum),
    .row_cy  (row_cy),
    .total   (total)
);

// File: tb/sim_quint_sum.sv
`timescale 1ns/1ps
module sim_quint_sum;
    localparam int WW = 16;
    localparam int WN = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [WW-1:0] a16, b16, c16, d16, e16, y16;
    logic [WN-1:0] a3, b3, c3, d3, e3, y3;

    int total_cnt = 0;
    int bad_cnt = 0;
    bit done = 1'b0;

    quint_sum #(.W(WW)) u0 (.op_a(a16), .op_b(b16), .op_c(c16), .op_d(d16), .op_e(e16), .total(y16));
    quint_sum #(.W(WN)) u1 (.op_a(a3), .op_b(b3), .op_c(c3), .op_d(d3), .op_e(e3), .total(y3));

    function automatic logic [WW-1:0] ref16(input logic [WW-1:0] p, q, r, s, t);
        logic [WW+2:0] acc;
        acc = {3'b0, p} + {3'b0, q} + {3'b0, r} + {3'b0, s} + {3'b0, t};
        return acc[WW-1:0];
    endfunction

    function automatic logic [WN-1:0] ref3(input logic [WN-1:0] p, q, r, s, t);
        int acc;
        acc = int'(p) + int'(q) + int'(r) + int'(s) + int'(t);
        return WN'(acc % (1 << WN));
    endfunction

    task automatic chk16(input string req, input logic [WW-1:0] exp);
        total_cnt++;
        if (y16 !== exp) begin
            bad_cnt++;
            $display("FAIL %s: total=%0h expected=%0h", req, y16, exp);
        end
    endtask

    task automatic chk3(input string req, input logic [WN-1:0] exp);
        total_cnt++;
        if (y3 !== exp) begin
            bad_cnt++;
            $display("FAIL %s: total=%0h expected=%0h", req, y3, exp);
        end
    endtask

    task automatic put16(input logic [WW-1:0] p, q, r, s, t);
        @(posedge clk);
        a16 = p; b16 = q; c16 = r; d16 = s; e16 = t;
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        if (!done) begin
            bad_cnt++;
            total_cnt++;
            $display("FAIL watchdog: expired expected=finish");
            $display("  test done: total=%0d bad=%0d", total_cnt, bad_cnt);
            $finish;
        end
    end

    initial begin : stim
        logic [WW-1:0] v [5];
        void'($urandom(32'd1234));
        a16 = '0; b16 = '0; c16 = '0; d16 = '0; e16 = '0;
        a3 = '0; b3 = '0; c3 = '0; d3 = '0; e3 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset state: zero operands give zero (R4)
        chk16("R4 reset-zero", '0);
        chk3("R4 reset-zero", '0);
        rst_n = 1'b1;

        // Exhaustive narrow instance, random wide instance (R4, R1, R2, R3)
        for (int k = 0; k < (1 << (5 * WN)); k++) begin
            @(posedge clk);
            {e3, d3, c3, b3, a3} = 15'(k);
            a16 = WW'($urandom); b16 = WW'($urandom); c16 = WW'($urandom);
            d16 = WW'($urandom); e16 = WW'($urandom);
            @(negedge clk);
            chk3("R4 exhaustive w3", ref3(a3, b3, c3, d3, e3));
            chk16("R4 random w16", ref16(a16, b16, c16, d16, e16));
        end

        // R1: column with all five ones gives count 5 in every column
        put16('1, '1, '1, '1, '1);
        chk16("R5 all-ones wrap", WW'((1 << WW) - 5));
        put16(16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000);
        chk16("R5 top-bit wrap", 16'h8000);
        put16(16'hFFFF, 16'h0001, 16'h0000, 16'h0000, 16'h0000);
        chk16("R5 single carry out", 16'h0000);
        put16(16'h5555, 16'hAAAA, 16'h5555, 16'hAAAA, 16'h5555);
        chk16("R1 mixed columns", ref16(16'h5555, 16'hAAAA, 16'h5555, 16'hAAAA, 16'h5555));
        put16(16'h0001, 16'h0001, 16'h0001, 16'h0001, 16'h0001);
        chk16("R2 count five in column 0", 16'h0005);
        put16(16'h4000, 16'h4000, 16'h4000, 16'h4000, 16'h0000);
        chk16("R3 column near top", 16'h0000);

        // R6: output follows an input change with no clock edge
        put16(16'h0010, 16'h0020, 16'h0030, 16'h0040, 16'h0050);
        chk16("R6 before change", 16'h00F0);
        #1 a16 = 16'h1000;
        #0.5;
        chk16("R6 after change", 16'h10E0);

        // R7: permutation of operands leaves total unchanged
        for (int n = 0; n < 40; n++) begin
            for (int j = 0; j < 5; j++) v[j] = WW'($urandom);
            put16(v[0], v[1], v[2], v[3], v[4]);
            chk16("R7 order base", ref16(v[0], v[1], v[2], v[3], v[4]));
            put16(v[3], v[0], v[4], v[2], v[1]);
            chk16("R7 order swapped", ref16(v[0], v[1], v[2], v[3], v[4]));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total_cnt, bad_cnt);
        $finish;
    end
endmodule